// File: doc/BRIEF.md
# Fractional-Increment Nanosecond Timebase

This block keeps a 64-bit time-of-day count in nanoseconds. While the run flag is set, every reference-clock cycle adds an integer tick period to the count. A 32-bit phase accumulator is fed with a programmable fraction, and each wrap of that accumulator adds one more nanosecond to that cycle's step. Rate can therefore be trimmed to sub-nanosecond resolution without stopping the count.

Phase is handled by a separate 64-bit offset. The reported time is the running count plus the offset, so software applies a relative step by changing only the offset, while the count keeps running. To set absolute time, software clears the offset and then loads the count. All 64-bit values go through a 32-bit register port. A low-word write is held in a staging register until the matching high-word write, and reading the low word of the reported time captures its high word for the read that follows. A one-cycle tick strobe marks every edge on which the count advanced, for use by downstream time comparators.

Top module: `todc_timebase`

## Requirements
- R1: After reset the count, offset, fraction accumulator, addend, control word, reported time and tick strobe are all zero.
- R2: While the run flag (control bit 2) is 0, the count does not change.
- R3: While the run flag is 1, each clock edge adds the integer period (control bits 25:16, unsigned) to the count, plus the carry defined in R4.
- R4: On each advancing edge the 32-bit accumulator adds the addend (register index 1) modulo 2^32. When that addition wraps, one extra nanosecond goes into the same edge's step. The accumulator holds when the count does not advance.
- R5: Reported time `now_o` equals count plus offset, modulo 2^64.
- R6: A write to the count low word (index 2) leaves the count unchanged. A write to the count high word (index 3) loads {written high, staged low} in one edge. That load takes priority over the advance on the same edge, and that edge neither advances nor moves the accumulator.
- R7: A write to the offset low word (index 4) leaves the offset unchanged until the offset high word (index 5) is written, and then both words update in one edge.
- R8: A read of index 6 returns the low word of the reported time and captures its high word. A read of index 7 returns that captured word, even if the time has since carried into the high word.
- R9: `tick_o` is 1 for exactly the cycle after each edge on which the count advanced, and 0 otherwise.
- R10: Reads of index 0 return only the run flag and the integer period at their bit positions. Index 1 returns the addend, and indices 2 to 5 return the live count and offset words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the snapshot on index 6) |
| reg_addr | input | 3 | Register word index 0 to 7 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the current state |
| now_o | output | 64 | Reported time, count plus offset |
| tick_o | output | 1 | Strobe on the cycle after each advance |

## Verification
The bench targets four corner cases.

- **Accumulator wrap.** Addends of a quarter, three quarters and one half are used, the last with a zero integer period. A design that dropped the carry, or applied it one edge late, would drift from the model within a few cycles.
- **Split 64-bit writes.** The bench writes the low word and waits several running cycles before writing the high word. A design that loaded the low word early, or let the advance overwrite the load, would show a wrong count.
- **Wrap of the reported time.** Count and offset are chosen so that their sum crosses 2^64.
- **Time snapshot.** The bench reads the low word just before the count carries into its high word. A design without a captured high word would return a torn time value.

// File: rtl/todc_pkg.sv
package todc_pkg;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_ADDEND = 3'd1,
    A_CNT_LO = 3'd2,
    A_CNT_HI = 3'd3,
    A_OFF_LO = 3'd4,
    A_OFF_HI = 3'd5,
    A_NOW_LO = 3'd6,
    A_NOW_HI = 3'd7
  } todc_addr_e;

  // step added to the count on an advancing edge: integer period plus carry
  function automatic logic [63:0] tick_step(input logic [63:0] iper, input logic carry);
    return iper + {63'd0, carry};
  endfunction

  // wrap-around sum of two words, returning the carry above the top bit
  function automatic logic [32:0] frac_add(input logic [31:0] a, input logic [31:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

endpackage

// File: rtl/todc_frac_acc.sv
module todc_frac_acc #(
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [FRAC_W-1:0] addend,
  output logic              carry,
  output logic [FRAC_W-1:0] frac_q
);
  logic [FRAC_W:0] sum;

  always_comb begin
    sum   = {1'b0, frac_q} + {1'b0, addend};
    carry = sum[FRAC_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   frac_q <= '0;
    else if (adv) frac_q <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/todc_split_reg.sv
module todc_split_reg #(
  parameter int HALF_W = 32,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wdata,
  output logic              ld_o,
  output logic [FULL_W-1:0] ld_val_o
);
  logic [HALF_W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stage_q <= '0;
    else if (wr_lo) stage_q <= wdata;
  end

  assign ld_o     = wr_hi;
  assign ld_val_o = {wdata, stage_q};
endmodule

// File: rtl/todc_count_core.sv
module todc_count_core #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [TIME_W-1:0] step,
  input  logic              load,
  input  logic [TIME_W-1:0] load_val,
  output logic [TIME_W-1:0] cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (adv)   cnt_q <= cnt_q + step;
  end
endmodule

// File: rtl/todc_timebase.sv
module todc_timebase #(
  parameter int WORD_W   = 32,
  parameter int IPER_W   = 10,
  parameter int IPER_LSB = 16,
  parameter int EN_BIT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [2:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [2*WORD_W-1:0] now_o,
  output logic              tick_o
);
  import todc_pkg::*;
  localparam int TIME_W = 2 * WORD_W;

  logic              en_q;
  logic [IPER_W-1:0] iper_q;
  logic [WORD_W-1:0] addend_q;
  logic [TIME_W-1:0] cnt_q, off_q, now_w, step_w;
  logic [WORD_W-1:0] snap_q;
  logic              tick_q;

  // named internal events
  logic wr_ctrl, wr_add, wr_clo, wr_chi, wr_olo, wr_ohi, rd_nlo;
  logic cnt_ld, off_ld, adv, carry;
  logic [TIME_W-1:0] cnt_ld_val, off_ld_val;
  logic [WORD_W-1:0] frac_q;

  todc_addr_e addr_e;
  assign addr_e = todc_addr_e'(reg_addr);

  assign wr_ctrl = reg_wr && (addr_e == A_CTRL);
  assign wr_add  = reg_wr && (addr_e == A_ADDEND);
  assign wr_clo  = reg_wr && (addr_e == A_CNT_LO);
  assign wr_chi  = reg_wr && (addr_e == A_CNT_HI);
  assign wr_olo  = reg_wr && (addr_e == A_OFF_LO);
  assign wr_ohi  = reg_wr && (addr_e == A_OFF_HI);
  assign rd_nlo  = reg_rd && (addr_e == A_NOW_LO);

  assign adv = en_q && !cnt_ld;

  todc_split_reg #(.HALF_W(WORD_W)) u_cnt_stage (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_clo), .wr_hi(wr_chi),
    .wdata(reg_wdata), .ld_o(cnt_ld), .ld_val_o(cnt_ld_val)
  );

  todc_split_reg #(.HALF_W(WORD_W)) u_off_stage (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_olo), .wr_hi(wr_ohi),
    .wdata(reg_wdata), .ld_o(off_ld), .ld_val_o(off_ld_val)
  );

  todc_frac_acc #(.FRAC_W(WORD_W)) u_frac (
    .clk(clk), .rst_n(rst_n), .adv(adv), .addend(addend_q),
    .carry(carry), .frac_q(frac_q)
  );

  assign step_w = TIME_W'(tick_step(64'(iper_q), carry));

  todc_count_core #(.TIME_W(TIME_W)) u_core (
    .clk(clk), .rst_n(rst_n), .adv(adv), .step(step_w),
    .load(cnt_ld), .load_val(cnt_ld_val), .cnt_q(cnt_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      iper_q   <= '0;
      addend_q <= '0;
      off_q    <= '0;
      snap_q   <= '0;
      tick_q   <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= reg_wdata[EN_BIT];
        iper_q <= reg_wdata[IPER_LSB +: IPER_W];
      end
      if (wr_add) addend_q <= reg_wdata;
      if (off_ld) off_q <= off_ld_val;
      if (rd_nlo) snap_q <= now_w[TIME_W-1:WORD_W];
      tick_q <= adv;
    end
  end

  assign now_w  = cnt_q + off_q;
  assign now_o  = now_w;
  assign tick_o = tick_q;

  always_comb begin
    reg_rdata = '0;
    case (addr_e)
      A_CTRL: begin
        reg_rdata[EN_BIT] = en_q;
        reg_rdata[IPER_LSB +: IPER_W] = iper_q;
      end
      A_ADDEND: reg_rdata = addend_q;
      A_CNT_LO: reg_rdata = cnt_q[WORD_W-1:0];
      A_CNT_HI: reg_rdata = cnt_q[TIME_W-1:WORD_W];
      A_OFF_LO: reg_rdata = off_q[WORD_W-1:0];
      A_OFF_HI: reg_rdata = off_q[TIME_W-1:WORD_W];
      A_NOW_LO: reg_rdata = now_w[WORD_W-1:0];
      A_NOW_HI: reg_rdata = snap_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/todc_sva.sv
module todc_sva #(
  parameter int TIME_W = 64,
  parameter int IPER_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              adv,
  input logic              carry,
  input logic              cnt_ld,
  input logic              off_ld,
  input logic [IPER_W-1:0] iper,
  input logic [TIME_W-1:0] cnt,
  input logic [TIME_W-1:0] off,
  input logic [TIME_W-1:0] now,
  input logic              tick
);
  // R1: state is zero on the first cycle after reset
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (cnt == '0) && (off == '0) && !tick);

  // R2: count holds while stopped and not loaded
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_ld) |=> $stable(cnt));

  // R3: an advancing edge moves the count by the period or the period plus one
  a_r3_step_range: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ((cnt - $past(cnt)) == TIME_W'($past(iper)))
         || ((cnt - $past(cnt)) == TIME_W'($past(iper)) + 1));

  // R4: a wrap of the accumulator yields the extra nanosecond
  a_r4_carry_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && carry) |=> (cnt - $past(cnt)) == TIME_W'($past(iper)) + 1);

  // R5: reported time is count plus offset
  a_r5_sum: assert property (@(posedge clk) disable iff (!rst_n)
    now == cnt + off);

  // R7: offset only moves on a high-word commit
  a_r7_offset_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !off_ld |=> $stable(off));

  // R9: strobe follows an advancing edge only
  a_r9_tick_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv) |=> !tick);
endmodule

bind todc_timebase todc_sva #(.TIME_W(2*WORD_W), .IPER_W(IPER_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .en(en_q), .adv(adv), .carry(carry),
  .cnt_ld(cnt_ld), .off_ld(off_ld), .iper(iper_q), .cnt(cnt_q),
  .off(off_q), .now(now_o), .tick(tick_o)
);

// File: tb/todc_timebase_bench.sv
module todc_timebase_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] now_o;
  logic        tick_o;

  int total = 0, bad = 0, cyc = 0;

  todc_timebase u_todc_timebase (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .now_o(now_o), .tick_o(tick_o)
  );

  always #10 clk = ~clk;

  // behavioural reference
  longint unsigned m_cnt = 0, m_off = 0, m_snap = 0;
  longint unsigned m_frac = 0, m_add = 0, m_iper = 0, m_cst = 0, m_ost = 0;
  bit m_en = 0, m_tick = 0;

  always @(posedge clk) begin
    bit ld, adv;
    longint unsigned s;
    if (!rst_n) begin
      m_cnt = 0; m_off = 0; m_snap = 0; m_frac = 0; m_add = 0; m_iper = 0;
      m_cst = 0; m_ost = 0; m_en = 0; m_tick = 0;
    end else begin
      ld  = reg_wr && reg_addr == 3;
      adv = m_en && !ld;
      if (reg_rd && reg_addr == 6) m_snap = (m_cnt + m_off) >> 32;
      if (adv) begin
        s = m_frac + m_add;
        m_frac = s & 64'hFFFF_FFFF;
        m_cnt = m_cnt + m_iper + (s >> 32);
      end
      if (reg_wr) begin
        case (reg_addr)
          0: begin m_en = reg_wdata[2]; m_iper = longint'(reg_wdata[25:16]); end
          1: m_add = longint'(reg_wdata);
          2: m_cst = longint'(reg_wdata);
          3: m_cnt = (longint'(reg_wdata) << 32) | m_cst;
          4: m_ost = longint'(reg_wdata);
          5: m_off = (longint'(reg_wdata) << 32) | m_ost;
          default: ;
        endcase
      end
      m_tick = adv;
    end
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic longint unsigned m_read(input int a);
    longint unsigned n = m_cnt + m_off;
    case (a)
      0: return (longint'(m_en) << 2) | (m_iper << 16);
      1: return m_add;
      2: return m_cnt & 64'hFFFF_FFFF;
      3: return m_cnt >> 32;
      4: return m_off & 64'hFFFF_FFFF;
      5: return m_off >> 32;
      6: return n & 64'hFFFF_FFFF;
      default: return m_snap;
    endcase
  endfunction

  task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every cycle: reported time (R5, R3, R4) and strobe (R9)
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 now_o", now_o, m_cnt + m_off);
      chk("R9 tick_o", longint'(tick_o), longint'(m_tick));
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_rd = 0; reg_addr = 3'(a); reg_wdata = d;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(input int a, input string tag, output logic [31:0] v);
    @(negedge clk);
    reg_rd = 1; reg_wr = 0; reg_addr = 3'(a);
    #2 chk(tag, longint'(reg_rdata), m_read(a));
    v = reg_rdata;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    logic [31:0] v, v2;
    idle(3);
    @(negedge clk) rst_n = 1;
    // R1 reset values
    for (int a = 0; a < 8; a++) begin
      rd(a, "R1 reset value", v);
      chk("R1 reset zero", longint'(v), 0);
    end
    // R10 control readback keeps only defined fields
    wr(0, 32'hFFFF_FFFB);
    rd(0, "R10 ctrl readback", v);
    chk("R10 ctrl literal", longint'(v), 64'h03FF_0000);
    wr(0, 32'h0000_0000);
    // R3 integer period only
    wr(0, (32'd8 << 16) | 32'h4);
    rd(2, "R3 count", v);
    rd(2, "R3 count", v2);
    chk("R3 step of 8", longint'(v2 - v), 8);
    idle(5);
    // R4 quarter addend
    wr(1, 32'h4000_0000);
    rd(1, "R10 addend readback", v);
    idle(12);
    rd(2, "R4 quarter fraction", v);
    // R4 three-quarter addend
    wr(1, 32'hC000_0000);
    idle(9);
    rd(2, "R4 three-quarter fraction", v);
    // R4 zero integer period, half addend
    wr(0, 32'h4);
    wr(1, 32'h8000_0000);
    idle(7);
    rd(2, "R4 half fraction zero period", v);
    // R2 stopped
    wr(0, (32'd3 << 16));
    rd(2, "R2 stopped", v);
    idle(4);
    rd(2, "R2 stopped", v2);
    chk("R2 held", longint'(v2), longint'(v));
    // R6 split count write while running
    wr(0, (32'd5 << 16) | 32'h4);
    wr(2, 32'hFFFF_FFF0);
    idle(3);
    rd(2, "R6 low not applied", v);
    rd(3, "R6 high not applied", v);
    wr(3, 32'h0000_1234);
    rd(3, "R6 high loaded", v);
    rd(2, "R6 low loaded", v);
    // R7 split offset write
    wr(4, 32'h0000_0100);
    idle(2);
    rd(4, "R7 offset low held", v);
    chk("R7 offset low literal", longint'(v), 0);
    wr(5, 32'h0000_0001);
    rd(5, "R7 offset high", v);
    rd(4, "R7 offset low", v);
    // R5 wrap of reported time
    wr(2, 32'hFFFF_FFF0);
    wr(3, 32'hFFFF_FFFF);
    wr(4, 32'h0000_0020);
    wr(5, 32'h0000_0000);
    idle(3);
    rd(6, "R5 wrapped low", v);
    rd(7, "R5 wrapped high", v);
    // R8 snapshot across carry into high word (absolute set: offset zero, then count)
    wr(4, 0); wr(5, 0);
    wr(0, (32'd8 << 16) | 32'h4);
    wr(1, 32'h0);
    wr(2, 32'hFFFF_FFE8);
    wr(3, 32'h0000_0000);
    rd(6, "R8 low read", v);
    idle(4);
    rd(7, "R8 captured high", v);
    chk("R8 captured high literal", longint'(v), 0);
    rd(3, "R8 live high moved", v2);
    chk("R8 live high literal", longint'(v2), 1);
    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule